// File: doc/BRIEF.md
# Modular Multiply-Accumulate Writeback Stage

This stage folds a stream of product coefficients into a stored vector of polynomials modulo the prime q. For each output row i it computes t[i] = e[i] + sum over j of product_j[i]. The work is done one coefficient at a time. The block walks three nested indices itself: coefficient position inside a polynomial, term j and row i. It steps the innermost index once for every valid product.

It drives a read address into two synchronous memories that answer one cycle later. The addend memory holds e, with row i stored at slot E_BASE + i. The running-sum memory holds t, with row i stored at slot i. The stage also drives the write port of the running-sum memory. For term 0 the addend comes from e. For every later term it comes from the value that the earlier terms left in t.

A `start` pulse arms a pass of K x K x N products. The `done` output pulses when the last sum has been written. The multiplier that feeds the product stream and the two memories sit outside this block.

Top module: `mac_wb_stage`

## Requirements
- R1: After reset `busy`, `done` and `t_we` are low, `t_rd_addr` is 0 and `e_rd_addr` is E_BASE*N.
- R2: Every written value equals (addend + product) mod Q, for inputs below Q. It is formed from a 13-bit sum with at most one subtraction of Q, so `t_wd` is always below Q.
- R3: For term j = 0 the addend is the addend-memory word at address (E_BASE + i)*N + n, where n is the coefficient position.
- R4: For terms j >= 1 the addend is the running-sum word at address i*N + n, which holds the sum of the earlier terms.
- R5: The read index is the position of the next product to be consumed: current position + 1 in a cycle with a valid product, and the current position otherwise. With an unbroken stream, `t_rd_addr` equals `t_wa` + 1 except at the last coefficient of a polynomial.
- R6: A valid product while busy writes `t_we`=1 at address `t_wa` = i*N + n, and n then advances by one. A cycle with `prod_valid` low writes nothing and leaves the position unchanged.
- R7: After position N-1 the position returns to 0 and j increments. After j = K-1, j returns to 0 and i increments. After the last product of row K-1, `done` is high for exactly the next cycle, `busy` is low in that cycle, and a new `start` begins again at row 0.
- R8: While the stage is not busy, `prod_valid` causes no write and `start` is the only input that has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms a pass while idle |
| prod_valid | input | 1 | Product coefficient present this cycle |
| prod_coeff | input | W | Product coefficient, below Q |
| e_rd_addr | output | EAW | Addend memory read address |
| e_rd_data | input | W | Addend memory data, one cycle after its address |
| t_rd_addr | output | TAW | Running-sum memory read address |
| t_rd_data | input | W | Running-sum memory data, one cycle after its address |
| t_we | output | 1 | Running-sum write enable |
| t_wa | output | TAW | Running-sum write address |
| t_wd | output | W | Running-sum write data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The write for a product is combinational in the cycle that product is presented. It lands in the memory model at the following rising edge. The data it depends on was read at the edge before, so the bench checks stored sums only after a pass has completed.

`done` is due one edge after the last product. The bench samples it at the falling edge that follows the last product's edge, and at the next falling edge it checks that `done` has dropped. Read addresses and `t_we` are combinational from registered indices. They are checked 1 ns after the inputs change, inside a bubble or idle cycle, and well before the next edge.

// File: rtl/mac_wb_pkg.sv
// Package: shared coefficient width and modulus defaults for the
// multiply-accumulate writeback stage.
package mac_wb_pkg;
    localparam int COEF_W = 12;
    localparam int MOD_Q  = 3329;
endpackage

// File: rtl/mac_modadd.sv
// mac_modadd: y = (a + b) mod Q.
// Assumes a < Q and b < Q, so a single conditional subtraction suffices.
module mac_modadd #(
    parameter int W = mac_wb_pkg::COEF_W,
    parameter int Q = mac_wb_pkg::MOD_Q
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] sum;
    logic [W:0] red;

    // Widened add, then subtract Q once if the sum reached Q.
    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        red = sum - (W+1)'(Q);
        y   = (sum >= (W+1)'(Q)) ? red[W-1:0] : sum[W-1:0];
    end
endmodule

// File: rtl/mac_idx_ctrl.sv
// mac_idx_ctrl: walks coefficient position, term and row for one pass.
// It exports both the current indices (write side) and the next-state
// indices (read side), so the read leads the write by one consumed product.
// Assumes the memories answer one cycle after their address.
module mac_idx_ctrl #(
    parameter int K = 3,
    parameter int N = 256,
    localparam int LOG_N = $clog2(N),
    localparam int IW    = (K > 1) ? $clog2(K) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             prod_valid,
    output logic             busy,
    output logic             done,
    output logic             first_q,
    output logic [IW-1:0]    i_cur,
    output logic [IW-1:0]    i_nx,
    output logic [LOG_N-1:0] o_cur,
    output logic [LOG_N-1:0] o_nx
);
    logic [IW-1:0] j_cur;
    logic [IW-1:0] j_nx;
    logic          adv;
    logic          last_o;
    logic          last_j;
    logic          last_i;
    logic          fin;

    // Next-state indices for the product consumed this cycle.
    always_comb begin
        adv    = busy & prod_valid;
        last_o = (o_cur == LOG_N'(N - 1));
        last_j = (j_cur == IW'(K - 1));
        last_i = (i_cur == IW'(K - 1));
        fin    = adv & last_o & last_j & last_i;
        o_nx   = o_cur;
        j_nx   = j_cur;
        i_nx   = i_cur;
        if (adv) begin
            o_nx = last_o ? '0 : o_cur + LOG_N'(1);
            if (last_o) begin
                j_nx = last_j ? '0 : j_cur + IW'(1);
                if (last_j) begin
                    i_nx = last_i ? '0 : i_cur + IW'(1);
                end
            end
        end
    end

    // Index registers, pass state and the delayed first-term select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            first_q <= 1'b1;
            i_cur   <= '0;
            j_cur   <= '0;
            o_cur   <= '0;
        end else begin
            first_q <= (j_nx == '0);
            done    <= fin;
            if (!busy) begin
                busy <= start;
            end else begin
                i_cur <= i_nx;
                j_cur <= j_nx;
                o_cur <= o_nx;
                if (fin) begin
                    busy <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mac_addr_gen.sv
// mac_addr_gen: forms memory addresses from row slot and coefficient index.
// Addend rows sit at slot E_BASE + i, running-sum rows at slot i.
// A power-of-two N uses field concatenation, otherwise a multiply.
module mac_addr_gen #(
    parameter int K      = 3,
    parameter int N      = 256,
    parameter int E_BASE = 3,
    localparam int LOG_N = $clog2(N),
    localparam int IW    = (K > 1) ? $clog2(K) : 1,
    localparam int TAW   = $clog2(K * N),
    localparam int EAW   = $clog2((E_BASE + K) * N)
) (
    input  logic [IW-1:0]    i_cur,
    input  logic [IW-1:0]    i_nx,
    input  logic [LOG_N-1:0] o_cur,
    input  logic [LOG_N-1:0] o_nx,
    output logic [EAW-1:0]   e_rd_addr,
    output logic [TAW-1:0]   t_rd_addr,
    output logic [TAW-1:0]   t_wa
);
    localparam int ESW = EAW - LOG_N;

    generate
        if (N == (1 << LOG_N)) begin : g_concat
            logic [ESW-1:0] e_slot;
            // Row slot in the high field, coefficient in the low field.
            always_comb begin
                e_slot    = ESW'(E_BASE) + ESW'(i_nx);
                e_rd_addr = {e_slot, o_nx};
                t_rd_addr = TAW'({i_nx, o_nx});
                t_wa      = TAW'({i_cur, o_cur});
            end
        end else begin : g_mul
            // Row slot times N plus coefficient index.
            always_comb begin
                e_rd_addr = (EAW'(E_BASE) + EAW'(i_nx)) * EAW'(N) + EAW'(o_nx);
                t_rd_addr = TAW'(i_nx) * TAW'(N) + TAW'(o_nx);
                t_wa      = TAW'(i_cur) * TAW'(N) + TAW'(o_cur);
            end
        end
    endgenerate
endmodule

// File: rtl/mac_wb_stage.sv
// mac_wb_stage: accumulates t[i] = e[i] + sum_j product_j[i] mod Q into the
// running-sum memory. Assumes both memories return data one cycle after the
// address and that every input coefficient is below Q.
module mac_wb_stage #(
    parameter int K      = 3,
    parameter int N      = 256,
    parameter int W      = mac_wb_pkg::COEF_W,
    parameter int Q      = mac_wb_pkg::MOD_Q,
    parameter int E_BASE = K,
    localparam int LOG_N = $clog2(N),
    localparam int IW    = (K > 1) ? $clog2(K) : 1,
    localparam int TAW   = $clog2(K * N),
    localparam int EAW   = $clog2((E_BASE + K) * N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           prod_valid,
    input  logic [W-1:0]   prod_coeff,
    output logic [EAW-1:0] e_rd_addr,
    input  logic [W-1:0]   e_rd_data,
    output logic [TAW-1:0] t_rd_addr,
    input  logic [W-1:0]   t_rd_data,
    output logic           t_we,
    output logic [TAW-1:0] t_wa,
    output logic [W-1:0]   t_wd,
    output logic           busy,
    output logic           done
);
    logic             first_q;
    logic [IW-1:0]    i_cur;
    logic [IW-1:0]    i_nx;
    logic [LOG_N-1:0] o_cur;
    logic [LOG_N-1:0] o_nx;
    logic [W-1:0]     addend;

    mac_idx_ctrl #(.K(K), .N(N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .prod_valid (prod_valid),
        .busy       (busy),
        .done       (done),
        .first_q    (first_q),
        .i_cur      (i_cur),
        .i_nx       (i_nx),
        .o_cur      (o_cur),
        .o_nx       (o_nx)
    );

    mac_addr_gen #(.K(K), .N(N), .E_BASE(E_BASE)) u_addr (
        .i_cur     (i_cur),
        .i_nx      (i_nx),
        .o_cur     (o_cur),
        .o_nx      (o_nx),
        .e_rd_addr (e_rd_addr),
        .t_rd_addr (t_rd_addr),
        .t_wa      (t_wa)
    );

    // Term 0 adds onto e, later terms onto the running sum.
    always_comb begin
        addend = first_q ? e_rd_data : t_rd_data;
        t_we   = busy & prod_valid;
    end

    mac_modadd #(.W(W), .Q(Q)) u_add (
        .a (addend),
        .b (prod_coeff),
        .y (t_wd)
    );
endmodule

// File: rtl/mac_wb_stage_chk.sv
// mac_wb_stage_chk: temporal checks on the writeback stage ports.
module mac_wb_stage_chk #(
    parameter int K      = 3,
    parameter int N      = 256,
    parameter int W      = 12,
    parameter int Q      = 3329,
    parameter int E_BASE = 3,
    localparam int TAW   = $clog2(K * N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           t_we,
    input logic [TAW-1:0] t_wa,
    input logic [TAW-1:0] t_rd_addr,
    input logic [W-1:0]   t_wd
);
    logic mid_poly;
    always_comb mid_poly = ((t_wa % TAW'(N)) != TAW'(N - 1));

    assert_wd_below_q_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t_we |-> (t_wd < W'(Q)));

    assert_read_leads_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (t_we && mid_poly) |-> (t_rd_addr == t_wa + TAW'(1)));

    assert_write_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_we && mid_poly) |=> (!t_we || (t_wa == $past(t_wa) + TAW'(1))));

    assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !t_we);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind mac_wb_stage mac_wb_stage_chk #(
    .K(K), .N(N), .W(W), .Q(Q), .E_BASE(E_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .t_we      (t_we),
    .t_wa      (t_wa),
    .t_rd_addr (t_rd_addr),
    .t_wd      (t_wd)
);

// File: tb/mac_wb_stage_tb.sv
// Bench for mac_wb_stage: memory models, vector table, full-pass model check.
module mac_wb_stage_tb;
    localparam int K   = 3;
    localparam int N   = 256;
    localparam int W   = 12;
    localparam int Q   = 3329;
    localparam int EB  = K;
    localparam int TAW = $clog2(K * N);
    localparam int EAW = $clog2((EB + K) * N);

    // Row 0 coefficients 0..7: e, p(j=0), p(j=1), p(j=2), expected sum.
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{0,    0,    0,    0,    0},
        '{3328, 1,    0,    0,    0},
        '{3328, 3328, 3328, 3328, 3325},
        '{1664, 1665, 0,    0,    0},
        '{1,    2,    3,    4,    10},
        '{3000, 328,  1,    0,    0},
        '{100,  3228, 1,    5,    5},
        '{2000, 2000, 2000, 2000, 1342}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           prod_valid = 1'b0;
    logic [W-1:0]   prod_coeff = '0;
    logic [EAW-1:0] e_rd_addr;
    logic [W-1:0]   e_rd_data;
    logic [TAW-1:0] t_rd_addr;
    logic [W-1:0]   t_rd_data;
    logic           t_we;
    logic [TAW-1:0] t_wa;
    logic [W-1:0]   t_wd;
    logic           busy;
    logic           done;

    logic [W-1:0] e_mem  [(EB + K) * N];
    logic [W-1:0] t_mem  [K * N];
    logic [W-1:0] prod_m [K * K * N];
    int           exp_m  [K * N];

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [31:0] rs = 32'h1234_5678;

    always #5 clk = ~clk;

    mac_wb_stage #(.K(K), .N(N), .W(W), .Q(Q), .E_BASE(EB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .prod_valid(prod_valid),
        .prod_coeff(prod_coeff), .e_rd_addr(e_rd_addr), .e_rd_data(e_rd_data),
        .t_rd_addr(t_rd_addr), .t_rd_data(t_rd_data), .t_we(t_we), .t_wa(t_wa),
        .t_wd(t_wd), .busy(busy), .done(done)
    );

    // Synchronous memories: one-cycle read, write on t_we.
    always @(posedge clk) begin
        e_rd_data <= e_mem[e_rd_addr];
        t_rd_data <= t_mem[t_rd_addr];
        if (t_we) t_mem[t_wa] <= t_wd;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return int'(rs % 32'(Q));
    endfunction

    task automatic fill(input logic [31:0] seed, input bit use_tab);
        rs = seed;
        for (int a = 0; a < (EB + K) * N; a++) e_mem[a] = W'(rnd());
        for (int a = 0; a < K * K * N; a++) prod_m[a] = W'(rnd());
        for (int a = 0; a < K * N; a++) t_mem[a] = '1;
        if (use_tab) begin
            for (int v = 0; v < NV; v++) begin
                e_mem[EB * N + v] = W'(VEC[v][0]);
                for (int j = 0; j < K; j++) prod_m[j * N + v] = W'(VEC[v][1 + j]);
            end
        end
        for (int i = 0; i < K; i++) begin
            for (int n = 0; n < N; n++) begin
                int acc;
                acc = int'(e_mem[(EB + i) * N + n]);
                for (int j = 0; j < K; j++) begin
                    acc = acc + int'(prod_m[(i * K + j) * N + n]);
                    if (acc >= Q) acc = acc - Q;
                end
                exp_m[i * N + n] = acc;
            end
        end
    endtask

    // One full pass; gap > 0 inserts an idle cycle before every gap-th product.
    task automatic run(input int gap);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < K; i++) begin
            for (int j = 0; j < K; j++) begin
                for (int n = 0; n < N; n++) begin
                    if (gap > 0 && (n % gap) == 3) begin
                        prod_valid = 1'b0;
                        #1;
                        chk(t_we == 1'b0, "R6 bubble write", int'(t_we), 0);
                        chk(t_rd_addr == TAW'(i * N + n), "R5 read index in bubble",
                            int'(t_rd_addr), i * N + n);
                        chk(e_rd_addr == EAW'((EB + i) * N + n), "R3 addend address",
                            int'(e_rd_addr), (EB + i) * N + n);
                        @(negedge clk);
                    end
                    prod_valid = 1'b1;
                    prod_coeff = prod_m[(i * K + j) * N + n];
                    @(negedge clk);
                end
            end
        end
        prod_valid = 1'b0;
        chk(done == 1'b1, "R7 done after last product", int'(done), 1);
        chk(busy == 1'b0, "R7 busy drops", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
    endtask

    task automatic compare_all(input string tag);
        for (int a = 0; a < K * N; a++) begin
            chk(int'(t_mem[a]) == exp_m[a], tag, int'(t_mem[a]), exp_m[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        fill(32'hC0FF_EE11, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(t_we == 1'b0, "R1 t_we", int'(t_we), 0);
        chk(t_rd_addr == '0, "R1 t_rd_addr", int'(t_rd_addr), 0);
        chk(e_rd_addr == EAW'(EB * N), "R1 e_rd_addr", int'(e_rd_addr), EB * N);

        // Pass 1 with bubbles; table rows hit the modulus corners.
        run(7);
        for (int v = 0; v < NV; v++) begin
            chk(int'(t_mem[v]) == VEC[v][4], "R2 R3 R4 table vector",
                int'(t_mem[v]), VEC[v][4]);
        end
        compare_all("R3 R4 pass one sum");

        // R8: products while idle must not write.
        prod_valid = 1'b1;
        prod_coeff = W'(5);
        for (int c = 0; c < 4; c++) begin
            #1;
            chk(t_we == 1'b0, "R8 idle product", int'(t_we), 0);
            chk(busy == 1'b0, "R8 stays idle", int'(busy), 0);
            @(negedge clk);
        end
        prod_valid = 1'b0;
        @(negedge clk);
        compare_all("R8 memory untouched");

        // Pass 2: new data, unbroken stream, restart from row 0.
        fill(32'h0BAD_5EED, 1'b0);
        run(0);
        compare_all("R5 R7 pass two sum");

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule